// File: doc/BRIEF.md
# Secure-Aware System Region Decoder

This block sits between a processor's load/store path and the registers of its private system region, a 1 MB space based at 0xE0000000. Each request carries an address, a read/write flag, a byte count, a secure attribute and an unprivileged (user) attribute. The block steers it to exactly one destination: the system-control register target, one of two banked timer register targets, a built-in local responder, or an external port for everything outside the region.

Windows overlap and are resolved by priority. The timer window sits inside the system-control window and wins over it, and the system-control window wins over the local responder, which answers everything else in the region. With the security extension enabled, a second page acts as an alias of the control and timer windows. Secure accesses to the alias reach the main targets as non-secure accesses. Non-secure accesses to the alias are answered locally. The downstream targets respond combinationally. The block registers the selected response and returns it one cycle after the request.

Top module: `sys_region_router`

## Requirements
- R1: A request whose address lies outside 0xE0000000..0xE00FFFFF pulses `ext_req` with `dn_addr` equal to the full request address, and the response carries the external port's data and error.
- R2: A privileged access to a region address that no window claims raises no downstream strobe. It gets an OK response with data 0, so a write has no effect.
- R3: An unprivileged access that the local responder answers returns an error.
- R4: The local responder, for a privileged access outside the alias page, accepts byte counts 1 to 8 (`req_size` holds the count in bytes). A count of 0 or more than 8 returns an error.
- R5: Addresses 0xE000E000..0xE000EFFF that are not in the timer window pulse `ctl_req`, with `dn_addr` equal to the offset from 0xE000E000.
- R6: Addresses 0xE000E010..0xE000E0EF go to a timer target in preference to the control target, with `dn_addr` equal to the offset from 0xE000E010.
- R7: In the timer window the secure attribute picks the bank. Secure selects `tmr_req[1]` and `tmr_rdata[63:32]`; non-secure selects `tmr_req[0]` and `tmr_rdata[31:0]`.
- R8: With `SEC_EXT`=1, a secure access to 0xE002E000..0xE002EFFF is forwarded to the target that the matching 0xE000Exxx address would reach, at the same offset, with `dn_secure` 0. An alias timer access therefore reaches bank 0.
- R9: With `SEC_EXT`=1, a non-secure access to the alias page raises no strobe. A privileged access returns data 0 with OK, whatever its byte count; an unprivileged access returns an error.
- R10: With `SEC_EXT`=0, alias-page addresses are handled by the local responder as unclaimed addresses, and every timer-window access uses bank 0 whatever the secure attribute.
- R11: `rsp_valid` is asserted exactly one cycle after each `req_valid` cycle. A write response carries data 0. A target's error is passed through to `rsp_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | SZW | Access size in bytes |
| req_wdata | input | DW | Write data |
| req_secure | input | 1 | Secure attribute |
| req_user | input | 1 | Unprivileged attribute |
| rsp_valid | output | 1 | Response present (registered) |
| rsp_rdata | output | DW | Read data (0 for writes) |
| rsp_err | output | 1 | Error status |
| ctl_req | output | 1 | Strobe to the system-control target |
| tmr_req | output | 2 | Strobes to timer bank 0 (non-secure) and bank 1 (secure) |
| ext_req | output | 1 | Strobe to the external port |
| dn_addr | output | AW | Window offset, or the full address on the external port |
| dn_write | output | 1 | Write flag to the targets |
| dn_size | output | SZW | Byte count to the targets |
| dn_wdata | output | DW | Write data to the targets |
| dn_secure | output | 1 | Effective secure attribute after alias remap |
| dn_user | output | 1 | Unprivileged attribute to the targets |
| ctl_rdata | input | DW | Control target read data |
| ctl_err | input | 1 | Control target error |
| tmr_rdata | input | 2*DW | Timer read data, bank 1 in the upper half |
| tmr_err | input | 2 | Timer errors, bank index by bit |
| ext_rdata | input | DW | External port read data |
| ext_err | input | 1 | External port error |

## Verification
The decode is combinational and the response register holds no history, so a wrong target choice shows up the same cycle as a wrong strobe, `dn_addr` or `dn_secure`. It shows up on the next cycle as wrong response data or status. The boundary addresses on each side of the timer window, the alias page with every secure/user combination, and both settings of the security parameter are the places where a priority or remap error would be visible. A lost or duplicated response would break the one-to-one pairing of requests and responses at once.

// File: rtl/sysrt_pkg.sv
package sysrt_pkg;
  typedef enum logic [2:0] {
    TGT_EXT   = 3'd0,
    TGT_CTL   = 3'd1,
    TGT_TMR0  = 3'd2,
    TGT_TMR1  = 3'd3,
    TGT_LOCAL = 3'd4
  } tgt_e;
endpackage

// File: rtl/sysrt_win.sv
module sysrt_win #(
  parameter int unsigned   AW   = 32,
  parameter logic [AW-1:0] BASE = '0,
  parameter int unsigned   SIZE = 4096
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] offset
);
  localparam logic [AW:0] LO = {1'b0, BASE};
  localparam logic [AW:0] HI = {1'b0, BASE} + (AW+1)'(SIZE);

  always_comb begin
    hit    = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    offset = addr - BASE;
  end
endmodule

// File: rtl/sysrt_local.sv
module sysrt_local #(
  parameter int unsigned SZW      = 4,
  parameter int unsigned MAX_SIZE = 8
) (
  input  logic           user,
  input  logic           alias_pg,
  input  logic [SZW-1:0] size,
  output logic           err
);
  logic size_bad;

  always_comb begin
    size_bad = (size == '0) || (size > SZW'(MAX_SIZE));
    err      = user || (!alias_pg && size_bad);
  end
endmodule

// File: rtl/sys_region_router.sv
module sys_region_router #(
  parameter int unsigned   AW          = 32,
  parameter int unsigned   DW          = 32,
  parameter int unsigned   SZW         = 4,
  parameter int unsigned   MAX_SIZE    = 8,
  parameter logic [AW-1:0] REGION_BASE = 32'hE000_0000,
  parameter int unsigned   REGION_SIZE = 32'h0010_0000,
  parameter logic [AW-1:0] CTL_OFS     = 32'h0000_E000,
  parameter int unsigned   CTL_SIZE    = 4096,
  parameter logic [AW-1:0] TMR_OFS     = 32'h0000_0010,
  parameter int unsigned   TMR_SIZE    = 32'h0000_00E0,
  parameter logic [AW-1:0] ALIAS_OFS   = 32'h0002_E000,
  parameter bit            SEC_EXT     = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic [SZW-1:0]  req_size,
  input  logic [DW-1:0]   req_wdata,
  input  logic            req_secure,
  input  logic            req_user,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_err,
  output logic            ctl_req,
  output logic [1:0]      tmr_req,
  output logic            ext_req,
  output logic [AW-1:0]   dn_addr,
  output logic            dn_write,
  output logic [SZW-1:0]  dn_size,
  output logic [DW-1:0]   dn_wdata,
  output logic            dn_secure,
  output logic            dn_user,
  input  logic [DW-1:0]   ctl_rdata,
  input  logic            ctl_err,
  input  logic [2*DW-1:0] tmr_rdata,
  input  logic [1:0]      tmr_err,
  input  logic [DW-1:0]   ext_rdata,
  input  logic            ext_err
);
  import sysrt_pkg::*;

  localparam logic [AW-1:0] CTL_BASE    = REGION_BASE + CTL_OFS;
  localparam logic [AW-1:0] TMR_BASE    = CTL_BASE + TMR_OFS;
  localparam logic [AW-1:0] ALIAS_DELTA = ALIAS_OFS - CTL_OFS;
  localparam int unsigned   NWIN        = 4;

  // window index: 0 main control, 1 main timer, 2 alias control, 3 alias timer
  logic [NWIN-1:0] whit;
  logic [AW-1:0]   woff [NWIN];
  logic            reg_hit;
  logic [AW-1:0]   reg_off;

  sysrt_win #(.AW(AW), .BASE(REGION_BASE), .SIZE(REGION_SIZE)) u_region (
    .addr(req_addr), .hit(reg_hit), .offset(reg_off)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [AW-1:0] WB = ((w % 2 == 0) ? CTL_BASE : TMR_BASE)
                                   + ((w >= 2) ? ALIAS_DELTA : '0);
    localparam int unsigned   WS = (w % 2 == 0) ? CTL_SIZE : TMR_SIZE;
    if (w < 2 || SEC_EXT) begin : g_on
      sysrt_win #(.AW(AW), .BASE(WB), .SIZE(WS)) u_win (
        .addr(req_addr), .hit(whit[w]), .offset(woff[w])
      );
    end else begin : g_off
      assign whit[w] = 1'b0;
      assign woff[w] = '0;
    end
  end

  tgt_e          tgt;
  logic [AW-1:0] sel_off;
  logic          eff_sec;
  logic          loc_err;
  logic          bank_sec;

  sysrt_local #(.SZW(SZW), .MAX_SIZE(MAX_SIZE)) u_local (
    .user(req_user), .alias_pg(whit[2]), .size(req_size), .err(loc_err)
  );

  always_comb begin
    bank_sec = req_secure && SEC_EXT;
    tgt      = TGT_LOCAL;
    sel_off  = reg_off;
    eff_sec  = req_secure;
    if (!reg_hit) begin
      tgt     = TGT_EXT;
      sel_off = req_addr;
    end else if (whit[1]) begin
      tgt     = bank_sec ? TGT_TMR1 : TGT_TMR0;
      sel_off = woff[1];
    end else if (whit[3] && req_secure) begin
      tgt     = TGT_TMR0;
      sel_off = woff[3];
      eff_sec = 1'b0;
    end else if (whit[0]) begin
      tgt     = TGT_CTL;
      sel_off = woff[0];
    end else if (whit[2] && req_secure) begin
      tgt     = TGT_CTL;
      sel_off = woff[2];
      eff_sec = 1'b0;
    end
  end

  always_comb begin
    ctl_req    = req_valid && (tgt == TGT_CTL);
    tmr_req[0] = req_valid && (tgt == TGT_TMR0);
    tmr_req[1] = req_valid && (tgt == TGT_TMR1);
    ext_req    = req_valid && (tgt == TGT_EXT);
    dn_addr    = sel_off;
    dn_write   = req_write;
    dn_size    = req_size;
    dn_wdata   = req_wdata;
    dn_secure  = eff_sec;
    dn_user    = req_user;
  end

  logic [DW-1:0] nxt_data;
  logic          nxt_err;

  always_comb begin
    unique case (tgt)
      TGT_EXT:  begin nxt_data = ext_rdata;            nxt_err = ext_err;    end
      TGT_CTL:  begin nxt_data = ctl_rdata;            nxt_err = ctl_err;    end
      TGT_TMR0: begin nxt_data = tmr_rdata[DW-1:0];    nxt_err = tmr_err[0]; end
      TGT_TMR1: begin nxt_data = tmr_rdata[2*DW-1:DW]; nxt_err = tmr_err[1]; end
      default:  begin nxt_data = '0;                   nxt_err = loc_err;    end
    endcase
    if (req_write) nxt_data = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? nxt_data : '0;
      rsp_err   <= req_valid && nxt_err;
    end
  end
endmodule

// File: rtl/sys_region_router_chk.sv
module sys_region_router_chk #(
  parameter int unsigned   AW          = 32,
  parameter logic [AW-1:0] REGION_BASE = 32'hE000_0000,
  parameter logic [AW-1:0] ALIAS_OFS   = 32'h0002_E000,
  parameter bit            SEC_EXT     = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_secure,
  input logic          req_user,
  input logic          ctl_req,
  input logic [1:0]    tmr_req,
  input logic          ext_req,
  input logic          dn_secure,
  input logic          rsp_valid,
  input logic          rsp_err
);
  localparam logic [AW-1:0] ALIAS_PG = REGION_BASE + ALIAS_OFS;

  logic in_region, in_alias, any_tgt;
  assign in_region = (req_addr[AW-1:20] == REGION_BASE[AW-1:20]);
  assign in_alias  = SEC_EXT && (req_addr[AW-1:12] == ALIAS_PG[AW-1:12]);
  assign any_tgt   = ctl_req || (tmr_req != 2'b00) || ext_req;

  a_r11_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r5_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_req, tmr_req, ext_req}));
  a_r1_outside_ext: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_region) |-> ext_req);
  a_r7_bank1_secure: assert property (@(posedge clk) disable iff (rst)
    tmr_req[1] |-> (req_secure && !in_alias && SEC_EXT));
  a_r8_alias_nonsecure_out: assert property (@(posedge clk) disable iff (rst)
    (in_alias && (ctl_req || tmr_req != 2'b00)) |-> !dn_secure);
  a_r9_alias_ns_local: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_alias && !req_secure) |-> !any_tgt);
  a_r3_user_local_err: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && !any_tgt) |=> rsp_err);
endmodule

bind sys_region_router sys_region_router_chk #(
  .AW(AW), .REGION_BASE(REGION_BASE), .ALIAS_OFS(ALIAS_OFS), .SEC_EXT(SEC_EXT)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_secure(req_secure), .req_user(req_user), .ctl_req(ctl_req),
  .tmr_req(tmr_req), .ext_req(ext_req), .dn_secure(dn_secure),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/sim_sys_region_router.sv
module sim_sys_region_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic        req_valid = 1'b0;
  logic [31:0] req_addr  = '0;
  logic        req_write = 1'b0;
  logic [3:0]  req_size  = 4'd4;
  logic [31:0] req_wdata = 32'h1234_5678;
  logic        req_secure = 1'b0;
  logic        req_user   = 1'b0;

  logic        rv [2];
  logic [31:0] rd [2];
  logic        re [2];
  logic        cq [2];
  logic [1:0]  tq [2];
  logic        eq [2];
  logic [31:0] da [2];
  logic        dw [2];
  logic [3:0]  dsz [2];
  logic [31:0] dwd [2];
  logic        dsec [2];
  logic        dusr [2];

  for (genvar i = 0; i < 2; i++) begin : g_dut
    logic [31:0] c_rd, x_rd;
    logic [63:0] t_rd;
    logic        c_er, x_er;
    assign c_rd = 32'hC000_0000 | da[i];
    assign c_er = (da[i][11:0] == 12'hFFC);
    assign t_rd = {32'hB000_0000 | da[i], 32'hA000_0000 | da[i]};
    assign x_rd = da[i] ^ 32'h5A5A_5A5A;
    assign x_er = (da[i][3:0] == 4'hF);
    if (i == 0) begin : g_sec
      sys_region_router #(.SEC_EXT(1'b1)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_secure(req_secure), .req_user(req_user),
        .rsp_valid(rv[i]), .rsp_rdata(rd[i]), .rsp_err(re[i]),
        .ctl_req(cq[i]), .tmr_req(tq[i]), .ext_req(eq[i]), .dn_addr(da[i]),
        .dn_write(dw[i]), .dn_size(dsz[i]), .dn_wdata(dwd[i]),
        .dn_secure(dsec[i]), .dn_user(dusr[i]),
        .ctl_rdata(c_rd), .ctl_err(c_er), .tmr_rdata(t_rd), .tmr_err(2'b00),
        .ext_rdata(x_rd), .ext_err(x_er));
    end else begin : g_nosec
      sys_region_router #(.SEC_EXT(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .req_secure(req_secure), .req_user(req_user),
        .rsp_valid(rv[i]), .rsp_rdata(rd[i]), .rsp_err(re[i]),
        .ctl_req(cq[i]), .tmr_req(tq[i]), .ext_req(eq[i]), .dn_addr(da[i]),
        .dn_write(dw[i]), .dn_size(dsz[i]), .dn_wdata(dwd[i]),
        .dn_secure(dsec[i]), .dn_user(dusr[i]),
        .ctl_rdata(c_rd), .ctl_err(c_er), .tmr_rdata(t_rd), .tmr_err(2'b00),
        .ext_rdata(x_rd), .ext_err(x_er));
    end
  end

  typedef struct packed {
    logic [3:0]  stb;   // {ctl, tmr1, tmr0, ext}
    logic [31:0] off;
    logic        sec;
    logic [31:0] rdata;
    logic        err;
  } exp_t;

  typedef struct packed {
    logic [31:0] rdata;
    logic        err;
  } rsp_t;

  rsp_t  sq [2][$];
  string tq_tag [2][$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic exp_t model(logic [31:0] a, logic wr, logic [3:0] sz,
                                 logic sec, logic usr, bit secx);
    exp_t e;
    logic in_reg, main_pg, alias_pg, tw;
    logic [11:0] lo;
    e = '0;
    in_reg   = (a[31:20] == 12'hE00);
    lo       = a[11:0];
    main_pg  = in_reg && (a[19:12] == 8'h0E);
    alias_pg = in_reg && secx && (a[19:12] == 8'h2E);
    tw       = (lo >= 12'h010) && (lo <= 12'h0EF);
    if (!in_reg) begin
      e.stb = 4'b0001; e.off = a; e.sec = sec;
      e.rdata = a ^ 32'h5A5A_5A5A; e.err = (a[3:0] == 4'hF);
    end else if (main_pg || (alias_pg && sec)) begin
      e.sec = main_pg ? (sec && secx) : 1'b0;
      if (tw) begin
        e.off   = {20'h0, lo - 12'h010};
        e.stb   = e.sec ? 4'b0100 : 4'b0010;
        e.rdata = (e.sec ? 32'hB000_0000 : 32'hA000_0000) | e.off;
      end else begin
        e.off = {20'h0, lo}; e.stb = 4'b1000;
        e.rdata = 32'hC000_0000 | e.off; e.err = (lo == 12'hFFC);
      end
      if (main_pg) e.sec = sec;
    end else begin
      e.stb = 4'b0000; e.rdata = '0;
      e.err = usr || (!alias_pg && (sz == 4'd0 || sz > 4'd8));
    end
    if (wr) e.rdata = '0;
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic wr, input logic [3:0] sz,
                       input logic sec, input logic usr, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz;
    req_secure = sec; req_user = usr; req_wdata = a ^ 32'hFFFF_0000;
    #1;
    for (int i = 0; i < 2; i++) begin
      exp_t e;
      logic [3:0] got;
      e   = model(a, wr, sz, sec, usr, (i == 0));
      got = {cq[i], tq[i][1], tq[i][0], eq[i]};
      checks++;
      if (got !== e.stb) begin
        fails++;
        $display("FAIL %s strobe inst%0d addr=%h actual=%b expected=%b", tag, i, a, got, e.stb);
      end
      if (e.stb != 4'b0000) begin
        checks++;
        if (da[i] !== e.off || dsec[i] !== e.sec || dw[i] !== wr || dusr[i] !== usr
            || dsz[i] !== sz || dwd[i] !== (a ^ 32'hFFFF_0000)) begin
          fails++;
          $display("FAIL %s dn inst%0d actual off=%h sec=%b expected off=%h sec=%b",
                   tag, i, da[i], dsec[i], e.off, e.sec);
        end
      end
      sq[i].push_back({e.rdata, e.err});
      tq_tag[i].push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: responses appear one cycle after the request (R11)
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if (rv[i]) begin
          checks++;
          if (sq[i].size() == 0) begin
            fails++;
            $display("FAIL R11 inst%0d unexpected response actual=1 expected=0", i);
          end else begin
            rsp_t x;
            string t;
            x = sq[i].pop_front();
            t = tq_tag[i].pop_front();
            if (rd[i] !== x.rdata || re[i] !== x.err) begin
              fails++;
              $display("FAIL %s rsp inst%0d actual=%h/%b expected=%h/%b",
                       t, i, rd[i], re[i], x.rdata, x.err);
            end
          end
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rv[0] !== 1'b0 || rv[1] !== 1'b0 || rd[0] !== 32'h0 || re[0] !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset state actual=%b%b expected=00", rv[0], rv[1]);
    end
    rst = 1'b0;
    idle(1);
    // R1 external port
    drive(32'h2000_0100, 1'b0, 4'd4, 1'b0, 1'b0, "R1");
    drive(32'h4000_000F, 1'b0, 4'd4, 1'b1, 1'b1, "R1_err");
    drive(32'hE010_0000, 1'b1, 4'd4, 1'b0, 1'b0, "R1_edge");
    // R2 unclaimed region, privileged
    drive(32'hE000_1000, 1'b0, 4'd4, 1'b0, 1'b0, "R2_rd");
    drive(32'hE000_1000, 1'b1, 4'd4, 1'b1, 1'b0, "R2_wr");
    drive(32'hE00F_FFFC, 1'b0, 4'd4, 1'b0, 1'b0, "R2_top");
    // R3 unprivileged local
    drive(32'hE000_1000, 1'b0, 4'd4, 1'b0, 1'b1, "R3");
    // R4 sizes
    drive(32'hE000_2000, 1'b0, 4'd0, 1'b0, 1'b0, "R4_sz0");
    drive(32'hE000_2000, 1'b0, 4'd9, 1'b0, 1'b0, "R4_sz9");
    drive(32'hE000_2000, 1'b0, 4'd8, 1'b0, 1'b0, "R4_sz8");
    drive(32'hE000_2000, 1'b1, 4'd1, 1'b0, 1'b0, "R4_sz1");
    // R5 control window
    drive(32'hE000_E004, 1'b0, 4'd4, 1'b0, 1'b0, "R5");
    drive(32'hE000_E00C, 1'b0, 4'd4, 1'b1, 1'b0, "R5_below_tmr");
    drive(32'hE000_E0F0, 1'b0, 4'd4, 1'b0, 1'b1, "R5_above_tmr");
    drive(32'hE000_EFFC, 1'b0, 4'd4, 1'b0, 1'b0, "R11_ctl_err");
    // R6/R7 timer window and banks
    drive(32'hE000_E010, 1'b0, 4'd4, 1'b0, 1'b0, "R6_low");
    drive(32'hE000_E0EC, 1'b0, 4'd4, 1'b1, 1'b0, "R7_secure");
    drive(32'hE000_E0EC, 1'b1, 4'd4, 1'b1, 1'b0, "R7_wr");
    drive(32'hE000_E020, 1'b0, 4'd4, 1'b0, 1'b1, "R7_ns");
    // R8 alias secure
    drive(32'hE002_E018, 1'b0, 4'd4, 1'b1, 1'b0, "R8_tmr");
    drive(32'hE002_E100, 1'b0, 4'd4, 1'b1, 1'b1, "R8_ctl");
    drive(32'hE002_E000, 1'b1, 4'd4, 1'b1, 1'b0, "R8_ctl_wr");
    idle(2);
    // R9 alias non-secure
    drive(32'hE002_E018, 1'b0, 4'd4, 1'b0, 1'b0, "R9_priv");
    drive(32'hE002_E200, 1'b0, 4'd0, 1'b0, 1'b0, "R9_priv_sz0");
    drive(32'hE002_E018, 1'b0, 4'd4, 1'b0, 1'b1, "R9_user");
    drive(32'hE002_E100, 1'b1, 4'd4, 1'b0, 1'b0, "R9_wr");
    // R10 variations seen on the second instance as well
    drive(32'hE002_E010, 1'b0, 4'd9, 1'b1, 1'b0, "R10_alias_size");
    drive(32'hE000_E050, 1'b0, 4'd4, 1'b1, 1'b1, "R10_tmr_sec");
    idle(3);
    for (int i = 0; i < 2; i++) begin
      checks++;
      if (sq[i].size() != 0) begin
        fails++;
        $display("FAIL R11 inst%0d missing responses actual=%0d expected=0", i, sq[i].size());
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule